// File: doc/BRIEF.md
# Debug Trace Text Logger

The block records a processor's debug signals as a text log on a character display. Each time the processor's step clock rises, the logger takes one snapshot of the debug bundle: program counter, instruction word, destination register index, both register read ports, register write data, and the two ALU operands with the ALU result. Each snapshot becomes one text row. Rows fill the screen from top to bottom. When the screen is full, logging continues again from the top row.

The step clock may run at any rate and needs no relation to the display clock. It is brought into the display domain by a two-flop synchroniser followed by a rising-edge detector. The display side supplies the current pixel position from a 1024x768 raster. The block returns a single pixel-on bit. Characters sit in 8x16 cells, which gives a 128 by 48 grid. Hex digits are drawn as seven-segment figures that are computed in logic. The block stores each captured record whole and formats it into text only as the display reads it.

Top module: `dtl_trace_logger`

## Requirements
- R1: While rst_ni is low and after its release, pixel_on_o is 0 and every row is blank until a step has been captured; the first captured step goes to row 0.
- R2: Each rising edge of step_i captures exactly one row, provided step_i stays high for at least 3 clk_i cycles and then low for at least 3. Keeping step_i high for longer adds no row. The bundle inputs must be stable from the rise until 4 cycles after it.
- R3: A row's text starts at column 0 and its fields are separated by one blank column. The field order and digit counts are: pc (8), instr (8), read index 1 (2), read index 2 (2), write index (2), read data 1 (8), read data 2 (8), write data (8), ALU A (8), ALU B (8), ALU result (8). This fills columns 0 to 79.
- R4: Read index 1 is shown as instr bits 25:21 and read index 2 as instr bits 20:16. The write index is wr_addr_i.
- R5: Every field is printed in hexadecimal with the most significant digit in the leftmost column. A 5-bit index prints as two digits, the upper one being 0 or 1.
- R6: Captured rows are written to rows 0, 1, ... 47 in that order. The 49th capture goes to row 0 and replaces that row's whole content. All other rows keep their content.
- R7: The cell column is pix_x_i/8, the cell row is pix_y_i/16, the glyph row is pix_y_i%16 and the glyph column is pix_x_i%8. pixel_on_o shows the pixel for the position sampled two clk_i edges earlier.
- R8: The following stay dark: rows that were never written, columns 80 to 127, blank separator columns, and positions with pix_y_i >= 768.
- R9: Digit d lights segments from the mask S[d] (bit0=a ... bit6=g): 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 B:7C C:39 D:5E E:79 F:71. The segments, as (glyph row, glyph column): a = row 2, columns 2-5; b = column 5, rows 2-7; c = column 5, rows 7-12; d = row 12, columns 2-5; e = column 2, rows 7-12; f = column 2, rows 2-7; g = row 7, columns 2-5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Processor step clock, asynchronous |
| pc_i | input | 32 | Program counter |
| instr_i | input | 32 | Instruction word |
| wr_addr_i | input | 5 | Destination register index |
| rd_data1_i | input | 32 | Register read port 1 data |
| rd_data2_i | input | 32 | Register read port 2 data |
| wr_data_i | input | 32 | Register write data |
| alu_a_i | input | 32 | ALU operand A |
| alu_b_i | input | 32 | ALU operand B |
| alu_y_i | input | 32 | ALU result |
| pix_x_i | input | 10 | Current pixel column |
| pix_y_i | input | 10 | Current pixel row |
| pixel_on_o | output | 1 | Foreground pixel for the position two cycles earlier |

## Verification
The assertions check, on every cycle, the following:
- a step edge yields a single capture pulse;
- the write row advances only on a capture and wraps from the last row to row 0;
- a captured row becomes valid on the next cycle;
- unwritten rows, columns past the text, and rows below the screen stay dark.

Only the bench scenarios can show that the rendered text is right. They check the digit order, the field placement, the instruction-derived register indices and the segment shapes. They also check that a long step pulse adds one row and no more, and that after the wrap row 0 holds the newest line while the other rows keep theirs.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  localparam int NUM_FIELDS = 11;
  localparam int LINE_LEN   = 80;  // 3*2 + 8*8 digits + 10 separators
  localparam logic [4:0] CODE_BLANK = 5'd16;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] instr;
    logic [4:0]  wr_addr;
    logic [31:0] rd1;
    logic [31:0] rd2;
    logic [31:0] wd;
    logic [31:0] alu_a;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
  } dbg_rec_t;

  function automatic int field_digits(int f);
    return (f >= 2 && f <= 4) ? 2 : 8;
  endfunction

  function automatic logic [31:0] field_val(dbg_rec_t r, int f);
    case (f)
      0:       return r.pc;
      1:       return r.instr;
      2:       return {27'd0, r.instr[25:21]};
      3:       return {27'd0, r.instr[20:16]};
      4:       return {27'd0, r.wr_addr};
      5:       return r.rd1;
      6:       return r.rd2;
      7:       return r.wd;
      8:       return r.alu_a;
      9:       return r.alu_b;
      default: return r.alu_y;
    endcase
  endfunction

  // Character code at a text column: 0..15 hex digit, 16 blank
  function automatic logic [4:0] char_code(dbg_rec_t r, int col);
    logic [4:0]  code;
    logic [31:0] v;
    logic [31:0] sh;
    int start;
    int nd;
    int k;
    code  = CODE_BLANK;
    start = 0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      v  = field_val(r, f);
      nd = field_digits(f);
      if (col >= start && col < start + nd) begin
        k    = start + nd - 1 - col;
        sh   = v >> (4 * k);
        code = {1'b0, sh[3:0]};
      end
      start = start + nd + 1;
    end
    return code;
  endfunction

  function automatic logic [6:0] seg_mask(logic [3:0] d);
    case (d)
      4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
      4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
      4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
      4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
    endcase
  endfunction

  function automatic logic seg_hit(logic [6:0] m, int gy, int gx);
    return (m[0] && gy == 2  && gx >= 2 && gx <= 5) ||
           (m[1] && gx == 5  && gy >= 2 && gy <= 7) ||
           (m[2] && gx == 5  && gy >= 7 && gy <= 12) ||
           (m[3] && gy == 12 && gx >= 2 && gx <= 5) ||
           (m[4] && gx == 2  && gy >= 7 && gy <= 12) ||
           (m[5] && gx == 2  && gy >= 2 && gy <= 7) ||
           (m[6] && gy == 7  && gx >= 2 && gx <= 5);
  endfunction
endpackage

// File: rtl/dtl_step_sync.sv
module dtl_step_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic capture_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], step_i};
      prev_q <= sync_q[1];
    end
  end

  assign capture_o = sync_q[1] & ~prev_q;

  p_one_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);
endmodule

// File: rtl/dtl_row_store.sv
module dtl_row_store
  import dtl_pkg::*;
#(
  parameter int ROWS  = 48,
  parameter int ROW_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  dbg_rec_t         wr_rec_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output dbg_rec_t         rd_rec_o,
  output logic             rd_vld_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  dbg_rec_t         mem [ROWS];
  logic [ROWS-1:0]  valid_q;
  logic [ROW_W-1:0] wr_row_q;
  logic             rd_in_range;
  logic [ROW_W-1:0] rd_idx;

  assign rd_in_range = (rd_row_i <= LAST_ROW);
  assign rd_idx      = rd_in_range ? rd_row_i : '0;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_row_q] <= wr_rec_i;
    rd_rec_o <= mem[rd_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      wr_row_q <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= rd_in_range && valid_q[rd_idx];
      if (wr_en_i) begin
        valid_q[wr_row_q] <= 1'b1;
        wr_row_q <= (wr_row_q == LAST_ROW) ? '0 : wr_row_q + 1'b1;
      end
    end
  end

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_row_q == LAST_ROW) |=> (wr_row_q == '0));
  p_ptr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_row_q));
  p_row_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_row_q)]);
endmodule

// File: rtl/dtl_render.sv
module dtl_render
  import dtl_pkg::*;
#(
  parameter int COL_W = 7,
  parameter int ROW_W = 6,
  parameter int ROWS  = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [3:0]       gy_i,
  input  logic [2:0]       gx_i,
  input  dbg_rec_t         rec_i,   // aligned with stage-1 registers
  input  logic             vld_i,
  output logic             pixel_on_o
);
  logic [COL_W-1:0] col_q;
  logic [3:0]       gy_q;
  logic [2:0]       gx_q;
  logic             oob_q;
  logic [4:0]       code;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      gy_q  <= '0;
      gx_q  <= '0;
      oob_q <= 1'b0;
    end else begin
      col_q <= col_i;
      gy_q  <= gy_i;
      gx_q  <= gx_i;
      oob_q <= (int'(row_i) >= ROWS);
    end
  end

  always_comb begin
    code = char_code(rec_i, int'(col_q));
    hit  = seg_hit(seg_mask(code[3:0]), int'(gy_q), int'(gx_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pixel_on_o <= 1'b0;
    else         pixel_on_o <= vld_i && !code[4] && hit;
  end

  p_dark_unwritten_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !pixel_on_o);
  p_dark_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(col_q) >= LINE_LEN) |=> !pixel_on_o);
  p_dark_below_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob_q |=> !pixel_on_o);
endmodule

// File: rtl/dtl_trace_logger.sv
module dtl_trace_logger
  import dtl_pkg::*;
#(
  parameter int COLS = 128,
  parameter int ROWS = 48
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           step_i,
  input  logic [31:0]                    pc_i,
  input  logic [31:0]                    instr_i,
  input  logic [4:0]                     wr_addr_i,
  input  logic [31:0]                    rd_data1_i,
  input  logic [31:0]                    rd_data2_i,
  input  logic [31:0]                    wr_data_i,
  input  logic [31:0]                    alu_a_i,
  input  logic [31:0]                    alu_b_i,
  input  logic [31:0]                    alu_y_i,
  input  logic [$clog2(COLS*8)-1:0]      pix_x_i,
  input  logic [$clog2(ROWS*16)-1:0]     pix_y_i,
  output logic                           pixel_on_o
);
  localparam int X_W   = $clog2(COLS * 8);
  localparam int Y_W   = $clog2(ROWS * 16);
  localparam int COL_W = X_W - 3;
  localparam int ROW_W = Y_W - 4;

  logic     capture;
  dbg_rec_t cap_rec;
  dbg_rec_t rd_rec;
  logic     rd_vld;

  always_comb begin
    cap_rec.pc      = pc_i;
    cap_rec.instr   = instr_i;
    cap_rec.wr_addr = wr_addr_i;
    cap_rec.rd1     = rd_data1_i;
    cap_rec.rd2     = rd_data2_i;
    cap_rec.wd      = wr_data_i;
    cap_rec.alu_a   = alu_a_i;
    cap_rec.alu_b   = alu_b_i;
    cap_rec.alu_y   = alu_y_i;
  end

  dtl_step_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .capture_o (capture)
  );

  dtl_row_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (capture),
    .wr_rec_i (cap_rec),
    .rd_row_i (pix_y_i[Y_W-1:4]),
    .rd_rec_o (rd_rec),
    .rd_vld_o (rd_vld)
  );

  dtl_render #(.COL_W(COL_W), .ROW_W(ROW_W), .ROWS(ROWS)) u_render (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .col_i      (pix_x_i[X_W-1:3]),
    .row_i      (pix_y_i[Y_W-1:4]),
    .gy_i       (pix_y_i[3:0]),
    .gx_i       (pix_x_i[2:0]),
    .rec_i      (rd_rec),
    .vld_i      (rd_vld),
    .pixel_on_o (pixel_on_o)
  );
endmodule

// File: tb/dtl_trace_logger_tb_top.sv
`timescale 1ns/1ps
module dtl_trace_logger_tb_top;
  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] instr;
    logic [4:0]  wa;
    logic [31:0] rd1, rd2, wd, a, b, y;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h00000044, 32'h00024280, 5'd8,  32'h00000000, 32'h00000007, 32'h00001C00,
      32'h00000007, 32'h0000000A, 32'h00001C00},
    '{32'h0000004C, 32'h00073982, 5'd7,  32'h00000000, 32'h00001D00, 32'h00000074,
      32'h00001D00, 32'h00000006, 32'h00000074},
    '{32'h00000058, 32'h000A59C3, 5'd11, 32'h00000000, 32'hFFFFFB00, 32'hFFFFFFF6,
      32'hFFFFFB00, 32'h00000007, 32'hFFFFFFF6},
    '{32'h89ABCDEF, 32'h01234567, 5'd31, 32'hDEADBEEF, 32'hCAFEF00D, 32'h13579BDF,
      32'h2468ACE0, 32'hFEDCBA98, 32'h76543210}
  };
  localparam logic [6:0] SEGS [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                                        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] pc = '0, instr = '0, rd1 = '0, rd2 = '0, wd = '0, a = '0, b = '0, y = '0;
  logic [4:0]  wa = '0;
  logic [9:0]  px = '0, py = '0;
  logic        pix;
  int          checks = 0;
  int          fails = 0;
  int          exp_line [128];
  int          pos;

  always #10 clk = ~clk;

  dtl_trace_logger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .pc_i(pc), .instr_i(instr),
    .wr_addr_i(wa), .rd_data1_i(rd1), .rd_data2_i(rd2), .wr_data_i(wd),
    .alu_a_i(a), .alu_b_i(b), .alu_y_i(y), .pix_x_i(px), .pix_y_i(py),
    .pixel_on_o(pix)
  );

  // Expected pixel from the segment geometry of R9
  function automatic logic exp_pix(int code, int gy, int gx);
    logic [6:0] m;
    logic on;
    if (code > 15) return 1'b0;
    m  = SEGS[code];
    on = 1'b0;
    if (gy == 2  && gx inside {[2:5]}  && m[0]) on = 1'b1;
    if (gy == 7  && gx inside {[2:5]}  && m[6]) on = 1'b1;
    if (gy == 12 && gx inside {[2:5]}  && m[3]) on = 1'b1;
    if (gx == 5  && gy inside {[2:7]}  && m[1]) on = 1'b1;
    if (gx == 5  && gy inside {[7:12]} && m[2]) on = 1'b1;
    if (gx == 2  && gy inside {[2:7]}  && m[5]) on = 1'b1;
    if (gx == 2  && gy inside {[7:12]} && m[4]) on = 1'b1;
    return on;
  endfunction

  task automatic put_field(logic [31:0] v, int nd);
    for (int d = nd - 1; d >= 0; d--) begin
      exp_line[pos] = int'((v >> (4 * d)) & 32'hF);
      pos++;
    end
    pos++;
  endtask

  // Builds the expected text of one row from R3, R4 and R5
  task automatic build_line(vec_t v);
    for (int i = 0; i < 128; i++) exp_line[i] = 16;
    pos = 0;
    put_field(v.pc, 8);
    put_field(v.instr, 8);
    put_field({27'd0, v.instr[25:21]}, 2);
    put_field({27'd0, v.instr[20:16]}, 2);
    put_field({27'd0, v.wa}, 2);
    put_field(v.rd1, 8);
    put_field(v.rd2, 8);
    put_field(v.wd, 8);
    put_field(v.a, 8);
    put_field(v.b, 8);
    put_field(v.y, 8);
  endtask

  // Streams the 128 pixels of one cell; output compared two edges later (R7)
  task automatic check_cell(int row, int col, int code, string tag);
    int mism = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if (pix !== exp_pix(code, (i - 2) / 8, (i - 2) % 8)) begin
          if (mism == 0) begin
            first_act = int'(pix);
            first_exp = int'(exp_pix(code, (i - 2) / 8, (i - 2) % 8));
          end
          mism++;
        end
      end
      if (i < 128) begin
        px = 10'(col * 8 + i % 8);
        py = 10'(row * 16 + i / 8);
      end
    end
    checks++;
    if (mism != 0) begin
      fails++;
      $display("FAIL %s row %0d col %0d: %0d pixels wrong, first actual %0d expected %0d",
               tag, row, col, mism, first_act, first_exp);
    end
  endtask

  task automatic check_row(int row, string tag);
    for (int c = 0; c < 82; c++) check_cell(row, c, exp_line[c], tag);
  endtask

  task automatic apply(vec_t v);
    pc = v.pc; instr = v.instr; wa = v.wa; rd1 = v.rd1; rd2 = v.rd2;
    wd = v.wd; a = v.a; b = v.b; y = v.y;
  endtask

  task automatic do_step(int hold);
    @(negedge clk);
    step = 1'b1;
    repeat (hold) @(negedge clk);
    step = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (pix !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset pixel: actual %0b expected 0", pix);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_cell(0, 0, 16, "R1 blank before capture");
    check_cell(47, 5, 16, "R1 R8 unwritten row");

    // Vector table: one capture per entry, full-row text check
    for (int k = 0; k < 4; k++) begin
      apply(VECS[k]);
      do_step(k == 2 ? 30 : 3);  // entry 2 holds the step high long (R2)
      build_line(VECS[k]);
      check_row(k, "R3 R4 R5 R9 row text");
      check_cell(k + 1, 0, 16, "R2 one row per step");
    end

    check_cell(0, 100, 16, "R8 column beyond text");
    check_cell(48, 0, 16, "R8 below screen");

    // Fill rows 4..47, then wrap to row 0 (R6)
    for (int j = 0; j < 44; j++) begin
      apply('{32'(4 + j), 32'd0, 5'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0});
      do_step(3);
    end
    apply(VECS[1]);
    do_step(3);
    build_line(VECS[1]);
    check_row(0, "R6 wrapped row replaced");
    check_cell(47, 6, 2, "R6 last row kept");
    check_cell(47, 7, 15, "R6 last row kept");
    build_line(VECS[1]);
    check_cell(1, 7, exp_line[7], "R6 row 1 kept");
    check_cell(1, 10, exp_line[10], "R6 row 1 kept");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule